// File: doc/BRIEF.md
# Serial Flash Main-Array Read Responder

This block is the device end of a serial flash read path. A bus master drops the chip select, clocks in an eight-bit command and a 24-bit address on the serial input, clocks through a fixed number of filler bytes, and then keeps toggling the serial clock to pull array bytes out, most significant bit first. The responder runs on its own system clock. It brings the serial clock, chip select and serial input through synchronizers and acts on the edges it detects. It drives the serial output together with a separate output enable, and a pad outside the block turns that pair into a three-state pin.

The main array is a pattern-initialized memory of 1056-byte pages. The page count is a power of two set by a parameter. Two commands are recognised. The page read keeps its byte pointer inside the addressed page. The continuous read steps through page ends and past the top of the array without pausing. Any other command byte leaves the output disabled until the select is released.

Top module: `sfr_read_responder`

## Requirements
- R1: While rst_n is low and directly after it is released, so_oe is 0.
- R2: Input bits are taken on rising SCK edges while cs_n is low, most significant bit first: 8 command bits, then 24 address bits. Address bits 23:11 form the page number, taken modulo the page count (2 by default). Bits 10:0 form the starting byte offset.
- R3: Command 8'hD2 is the page read. After the address come 4 filler bytes (32 rising edges) with so_oe held at 0. The first data bit is driven on the falling SCK edge that follows the last filler rising edge.
- R4: so and so_oe change only after falling SCK edges. Each byte goes out bit 7 first, and so_oe rises with the first data bit.
- R5: In a page read, the byte after offset 1055 is offset 0 of the same page.
- R6: Command 8'h0B is the continuous read, with 1 filler byte. The byte after offset 1055 is offset 0 of the next page, with no extra SCK cycles.
- R7: In a continuous read, the byte after offset 1055 of the last page is offset 0 of page 0, with no extra SCK cycles.
- R8: Raising cs_n ends any command. so_oe is 0 no more than 4 clk cycles later. The next low period of cs_n starts again with a fresh command byte.
- R9: Any other command byte keeps so_oe at 0 for the rest of that cs_n low period, whatever is clocked in.
- R10: The byte stored at page p, offset b is (b + 37*p) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run well faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; 0 means high impedance |

## Verification
Every pin passes two synchronizer flops and one state register. A change on SCK or cs_n therefore reaches so and so_oe on the third clk edge after the first edge that samples it. The checks on SCK edges in the bound checker look exactly four samples back for that reason. The bench holds each SCK half-period for 8 clk cycles and samples so and so_oe at the end of the low half, well after the update from the preceding falling edge has settled. After releasing cs_n it waits 4 clk cycles before checking that the output has turned off.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam int        PAGE_BYTES  = 1056;
    localparam int        OFF_W       = 11;
    localparam int        ADDR_BITS   = 24;
    localparam int        FILL_STRIDE = 37;
    localparam logic [7:0] OPC_PAGE_RD = 8'hD2;
    localparam logic [7:0] OPC_CONT_RD = 8'h0B;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_SINK
    } phase_e;

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/sfr_array.sv
module sfr_array
    import sfr_pkg::*;
#(
    parameter int PAGE_BITS = 1
) (
    input  logic [PAGE_BITS-1:0] page,
    input  logic [OFF_W-1:0]     off,
    output logic [7:0]           data
);

    localparam int PAGES = 1 << PAGE_BITS;
    localparam int DEPTH = PAGES * PAGE_BYTES;
    localparam int IW    = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [IW-1:0] idx;

    // Contents come from an address formula; the array is never written.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = 8'((i % PAGE_BYTES) + FILL_STRIDE * (i / PAGE_BYTES));
        end
    end

    assign idx  = IW'(page) * IW'(PAGE_BYTES) + IW'(off);
    assign data = mem[idx];

endmodule

// File: rtl/sfr_addr_step.sv
module sfr_addr_step
    import sfr_pkg::*;
#(
    parameter int PAGE_BITS = 1
) (
    input  logic [PAGE_BITS-1:0] page,
    input  logic [OFF_W-1:0]     off,
    input  logic                 cont,
    output logic [PAGE_BITS-1:0] page_nx,
    output logic [OFF_W-1:0]     off_nx
);

    logic at_end;

    assign at_end = (off == OFF_W'(PAGE_BYTES - 1));

    // Page count is a power of two, so the page increment wraps by itself.
    always_comb begin
        off_nx  = at_end ? '0 : off + OFF_W'(1);
        page_nx = (at_end && cont) ? page + PAGE_BITS'(1) : page;
    end

endmodule

// File: rtl/sfr_read_responder.sv
module sfr_read_responder
    import sfr_pkg::*;
#(
    parameter int PAGE_BITS  = 1,
    parameter int DUMMY_PAGE = 4,
    parameter int DUMMY_CONT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic so,
    output logic so_oe
);

    localparam int MAXD    = (DUMMY_PAGE > DUMMY_CONT) ? DUMMY_PAGE : DUMMY_CONT;
    localparam int CNT_W   = $clog2(MAXD * 8 + ADDR_BITS + 1);
    localparam int SR_W    = OFF_W + PAGE_BITS - 1;
    localparam int DB_PAGE = DUMMY_PAGE * 8;
    localparam int DB_CONT = DUMMY_CONT * 8;

    typedef struct packed {
        phase_e               phase;
        logic                 sck_prev;
        logic [6:0]           cmd;
        logic [SR_W-1:0]      adr;
        logic [CNT_W-1:0]     cnt;
        logic                 cont;
        logic [PAGE_BITS-1:0] page;
        logic [OFF_W-1:0]     off;
        logic [2:0]           obit;
        logic                 so;
        logic                 oe;
    } st_t;

    st_t q, n;

    logic                 cs_s, sck_s, si_s;
    logic                 rise, fall;
    logic [7:0]           opc;
    logic [SR_W:0]        cap;
    logic [7:0]           rd_byte;
    logic [PAGE_BITS-1:0] page_nx;
    logic [OFF_W-1:0]     off_nx;
    int                   dummy_bits;

    sfr_sync #(
        .W       (3),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, si}),
        .q     ({cs_s, sck_s, si_s})
    );

    sfr_array #(
        .PAGE_BITS (PAGE_BITS)
    ) u_array (
        .page (q.page),
        .off  (q.off),
        .data (rd_byte)
    );

    sfr_addr_step #(
        .PAGE_BITS (PAGE_BITS)
    ) u_step (
        .page    (q.page),
        .off     (q.off),
        .cont    (q.cont),
        .page_nx (page_nx),
        .off_nx  (off_nx)
    );

    assign rise       = sck_s & ~q.sck_prev;
    assign fall       = ~sck_s & q.sck_prev;
    assign opc        = {q.cmd, si_s};
    assign cap        = {q.adr, si_s};
    assign dummy_bits = q.cont ? DB_CONT : DB_PAGE;

    always_comb begin
        n          = q;
        n.sck_prev = sck_s;
        if (cs_s) begin
            n.phase = PH_CMD;
            n.cnt   = '0;
            n.oe    = 1'b0;
        end else if (rise) begin
            case (q.phase)
                PH_CMD: begin
                    n.cmd = opc[6:0];
                    n.cnt = q.cnt + CNT_W'(1);
                    if (q.cnt == CNT_W'(7)) begin
                        n.cnt = '0;
                        if (opc == OPC_PAGE_RD) begin
                            n.phase = PH_ADDR;
                            n.cont  = 1'b0;
                        end else if (opc == OPC_CONT_RD) begin
                            n.phase = PH_ADDR;
                            n.cont  = 1'b1;
                        end else begin
                            n.phase = PH_SINK;
                        end
                    end
                end
                PH_ADDR: begin
                    n.adr = cap[SR_W-1:0];
                    n.cnt = q.cnt + CNT_W'(1);
                    if (q.cnt == CNT_W'(ADDR_BITS - 1)) begin
                        n.cnt   = '0;
                        n.page  = cap[OFF_W +: PAGE_BITS];
                        n.off   = cap[OFF_W-1:0];
                        n.obit  = '0;
                        n.phase = (dummy_bits == 0) ? PH_DATA : PH_DUMMY;
                    end
                end
                PH_DUMMY: begin
                    n.cnt = q.cnt + CNT_W'(1);
                    if (int'(q.cnt) == dummy_bits - 1) begin
                        n.cnt   = '0;
                        n.phase = PH_DATA;
                    end
                end
                default: ;
            endcase
        end else if (fall && q.phase == PH_DATA) begin
            n.so   = rd_byte[3'd7 - q.obit];
            n.oe   = 1'b1;
            n.obit = q.obit + 3'd1;
            if (q.obit == 3'd7) begin
                n.page = page_nx;
                n.off  = off_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign so    = q.so;
    assign so_oe = q.oe;

endmodule

// File: rtl/sfr_read_responder_chk.sv
module sfr_read_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic cs_n,
    input logic so,
    input logic so_oe
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            rst_oe_low_chk: assert (!so_oe);
        end
    end

    // R8
    oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> !$past(cs_n, 3));

    // R4
    oe_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> ($past(sck, 4) && !$past(sck, 3)));

    // R4
    so_move_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && !$stable(so)) |-> ($past(sck, 4) && !$past(sck, 3)));

endmodule

bind sfr_read_responder sfr_read_responder_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sck   (sck),
    .cs_n  (cs_n),
    .so    (so),
    .so_oe (so_oe)
);

// File: tb/sfr_read_responder_bench.sv
module sfr_read_responder_bench;

    localparam int PAGES = 2;
    localparam int LAST  = 1055;
    localparam int HALF  = 8;
    localparam int NV    = 7;

    typedef struct packed {
        logic [7:0]  opc;
        logic [12:0] page;
        logic [10:0] off;
        logic [7:0]  nbytes;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'hD2, 13'd0, 11'd5,    8'd4},  // R3 plain page read
        '{8'hD2, 13'd1, 11'd1053, 8'd5},  // R5 wrap inside page
        '{8'h0B, 13'd0, 11'd1054, 8'd4},  // R6 page crossover
        '{8'h0B, 13'd1, 11'd1054, 8'd4},  // R7 end of array wrap
        '{8'hD2, 13'd5, 11'd300,  8'd3},  // R2 page number modulo count
        '{8'h0B, 13'd0, 11'd0,    8'd3},  // R10 pattern at array start
        '{8'hD2, 13'd0, 11'd1055, 8'd2}   // R5 start on last byte
    };
    localparam string VREQ [NV] = '{"R3", "R5", "R6", "R7", "R2", "R10", "R5"};

    logic clk = 1'b0;
    logic rst_n, sck, cs_n, si;
    logic so, so_oe;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #2.5 clk = ~clk;

    sfr_read_responder u_sfr_read_responder (
        .clk   (clk),
        .rst_n (rst_n),
        .sck   (sck),
        .cs_n  (cs_n),
        .si    (si),
        .so    (so),
        .so_oe (so_oe)
    );

    function automatic logic [7:0] pat(input int p, input int b);
        return 8'((b + 37 * (p % PAGES)) % 256);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic sck_bit(input logic b, output logic so_smp, output logic oe_smp);
        @(negedge clk);
        si = b;
        repeat (HALF - 1) @(negedge clk);
        so_smp = so;
        oe_smp = so_oe;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic send_header(input logic [7:0] opc, input logic [23:0] adr,
                               input int nfill, output logic oe_seen);
        logic s, o;
        oe_seen = 1'b0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            sck_bit(opc[i], s, o);
            oe_seen |= o;
        end
        for (int i = 23; i >= 0; i--) begin
            sck_bit(adr[i], s, o);
            oe_seen |= o;
        end
        for (int i = 0; i < nfill * 8; i++) begin
            sck_bit(1'b0, s, o);
            oe_seen |= o;
        end
    endtask

    task automatic read_byte(output logic [7:0] v, output logic oe_all);
        logic s, o;
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sck_bit(1'b0, s, o);
            v[i] = s;
            oe_all &= o;
        end
    endtask

    task automatic release_cs;
        @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        logic       oe_seen, oe_all, s, o;
        logic [7:0] got;
        int         p, b;
        bit         cont;

        rst_n = 1'b0;
        sck   = 1'b0;
        cs_n  = 1'b1;
        si    = 1'b0;
        repeat (6) @(negedge clk);
        chk(so_oe == 1'b0, "R1 in reset", so_oe, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(so_oe == 1'b0, "R1 after reset", so_oe, 0);

        // Table walk: each vector is one full command and its data bytes.
        for (int v = 0; v < NV; v++) begin
            cont = (VECS[v].opc == 8'h0B);
            send_header(VECS[v].opc, {VECS[v].page, VECS[v].off}, cont ? 1 : 4, oe_seen);
            chk(oe_seen == 1'b0, {VREQ[v], " R3 output off in header"}, oe_seen, 0);
            p = int'(VECS[v].page) % PAGES;
            b = int'(VECS[v].off);
            for (int k = 0; k < int'(VECS[v].nbytes); k++) begin
                read_byte(got, oe_all);
                chk(oe_all == 1'b1, {VREQ[v], " R4 output on in data"}, oe_all, 1);
                chk(got == pat(p, b), {VREQ[v], " data byte"}, got, pat(p, b));
                if (b == LAST) begin
                    b = 0;
                    if (cont) p = (p + 1) % PAGES;
                end else begin
                    b++;
                end
            end
            release_cs();
        end

        // R9: unknown command byte, then plenty of clocks
        send_header(8'h55, 24'hFFFFFF, 2, oe_seen);
        for (int i = 0; i < 16; i++) begin
            sck_bit(1'b1, s, o);
            oe_seen |= o;
        end
        chk(oe_seen == 1'b0, "R9 unknown command keeps output off", oe_seen, 0);
        release_cs();

        // R8: abort in the middle of a byte
        send_header(8'hD2, {13'd0, 11'd10}, 4, oe_seen);
        read_byte(got, oe_all);
        chk(got == pat(0, 10), "R8 byte before abort", got, pat(0, 10));
        for (int i = 0; i < 3; i++) sck_bit(1'b0, s, o);
        chk(so_oe == 1'b1, "R8 driving before abort", so_oe, 1);
        @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(so_oe == 1'b0, "R8 off 4 clk after select release", so_oe, 0);
        repeat (4) @(negedge clk);

        // R8: next select period starts with a fresh command
        send_header(8'h0B, {13'd1, 11'd2}, 1, oe_seen);
        chk(oe_seen == 1'b0, "R8 header after abort", oe_seen, 0);
        read_byte(got, oe_all);
        chk(got == pat(1, 2), "R8 first byte after abort", got, pat(1, 2));
        read_byte(got, oe_all);
        chk(got == pat(1, 3), "R8 second byte after abort", got, pat(1, 3));
        release_cs();

        // R8: SCK activity with select high leaves output off
        for (int i = 0; i < 12; i++) sck_bit(1'b1, s, o);
        chk(so_oe == 1'b0, "R8 select high ignores SCK", so_oe, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule